// File: doc/BRIEF.md
# Buffered Dataway Interface Controller

This block is the digital core of a dataway module that links a crate controller to a slow serial link. On every dataway cycle that addresses the station, it decodes the function and subaddress codes. It returns the read word together with the Q and X responses, and it moves words between two buffers. Command words written by the host go into a small output buffer, and the serial link engine drains that buffer through a valid/ready handshake. Response words from the link are pushed into a 40-word input FIFO. Each response word can carry an end-of-block marker. The host reads the FIFO in arrival order, and a read of an empty FIFO returns Q=0.

The controller keeps two request flags. The data flag (L1) follows the occupancy of the response FIFO. The block flag (L2) latches when a word marked as the end of a response arrives. A sticky overflow bit records a response word that was dropped because the FIFO was full. The LAM output is raised while either request flag is set. Both dataway clear inputs return the block to its empty, idle state.

The dataway cycle is presented as a one-clock strobe with the station select, subaddress, function and write data held stable. The read data, Q and X are registered on that edge and stay valid until the next addressed strobe.

Top module: `cdw_buffered_if`

## Requirements
- R1: Response words are stored in a FIFO of RSP_DEPTH (40) words and read back in arrival order. A word that arrives while the FIFO is full, with no read in the same cycle, is discarded.
- R2: Function 0 with subaddress 0 or 1 returns the flag word: bit 0 = L1, bit 1 = L2, bit 2 = overflow, all other bits 0. The response is Q=1, X=1.
- R3: Function 2 with subaddress 0 or 1 returns the oldest response word, removes it and gives Q=1. On an empty FIFO it returns 0 with Q=0, and nothing is removed.
- R4: Function 9 with subaddress 0 empties both buffers and clears L1, L2 and overflow, with Q=1, X=1. A response word arriving in the same cycle is discarded and does not set L2.
- R5: Function 16 (any subaddress) stores the write word into the CMD_DEPTH (4) entry command buffer with Q=1 when there is room. When the buffer is full it gives Q=0 and the word is not stored. Stored words leave on cmdWord in order, one per cycle in which cmdValid and cmdReady are both high.
- R6: Function 27 with subaddress 0 returns Q equal to L1, with X=1.
- R7: L2 is set when a response word marked with rspLast arrives, and it stays set until a function 9 or a dataway clear. Unmarked words never set it.
- R8: L1 is 1 exactly while the response FIFO holds at least one word. A read and a new word in the same cycle keep the new word.
- R9: dwClear or dwInit empties both buffers, clears all flags and forces rdData=0, Q=0, X=0.
- R10: The overflow bit is set by a discarded response word and stays set through reads until a function 9 or a dataway clear.
- R11: X=1 only for the pairs listed in R2 to R6. Any other pair gives X=0, Q=0 and rdData=0, and changes no buffer or flag.
- R12: A strobe without station select changes no state, and rdData, Q and X keep their previous values.
- R13: lamReq is high exactly when L1 or L2 is set.
- R14: rdData, qResp and xResp are registered at the clock edge that samples the strobe. They are valid from the following cycle and hold until the next addressed strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dwClear | input | 1 | Dataway clear, one-cycle pulse |
| dwInit | input | 1 | Dataway initialise, one-cycle pulse |
| cycStb | input | 1 | One-cycle strobe marking a dataway cycle |
| stationSel | input | 1 | Station addressed |
| subAddr | input | 4 | Subaddress code |
| func | input | 5 | Function code |
| wrData | input | 24 | Write data for function 16 |
| rdData | output | 24 | Read data, registered |
| qResp | output | 1 | Q response, registered |
| xResp | output | 1 | X response, registered |
| lamReq | output | 1 | LAM request (L1 or L2) |
| cmdValid | output | 1 | Command word available to the link |
| cmdReady | input | 1 | Link takes the command word |
| cmdWord | output | 24 | Oldest command word |
| rspValid | input | 1 | Response word push |
| rspWord | input | 24 | Response word |
| rspLast | input | 1 | Marks the last word of a response |

## Verification
The bench sweeps every function and subaddress pair on an idle block and checks X, Q and the read word against a decode table it computes itself. A decoder that accepted extra pairs, or that answered unimplemented pairs with Q=1, would show up on the first wrong pair. It fills the response FIFO to exactly 40 words, pushes one more and reads everything back. This catches an off-by-one depth, a 41st word that slips into the FIFO, and an overflow bit that does not stay set. Collisions in a single cycle are tested: a read together with a new word, where a wrong design loses one of the two, and a clear together with a new word, where a wrong design keeps the word or sets L2. The bench also checks that unaddressed strobes and unimplemented pairs leave the FIFO contents and the held responses untouched.

// File: rtl/cdw_pkg.sv
`timescale 1ns/1ps
package cdw_pkg;
  localparam logic [4:0] FN_RD_FLAGS = 5'd0;
  localparam logic [4:0] FN_RD_ADV   = 5'd2;
  localparam logic [4:0] FN_FLUSH    = 5'd9;
  localparam logic [4:0] FN_WRITE    = 5'd16;
  localparam logic [4:0] FN_TEST_L1  = 5'd27;

  typedef struct packed {
    logic flush;
    logic rspPop;
    logic cmdPush;
  } ctlStrobes_t;
endpackage

// File: rtl/cdw_fifo.sv
`timescale 1ns/1ps
module cdw_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 pushData,
  input  logic                         pop,
  output logic [W-1:0]                 headData,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (level == '0);
  assign full     = (level == LVL_W'(DEPTH));
  assign doPop    = pop & ~empty & ~flush;
  assign doPush   = push & ~flush & (~full | doPop);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      unique case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R1: occupancy never exceeds the configured depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  // R1: a push into a full FIFO without a pop leaves occupancy unchanged
  a_r1_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> $stable(level));
  // R4: flush leaves the FIFO empty
  a_r4_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
endmodule

// File: rtl/cdw_datapath.sv
`timescale 1ns/1ps
module cdw_datapath
  import cdw_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int RSP_DEPTH = 40,
  parameter int CMD_DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobes_t                       strobes,
  input  logic [WORD_W-1:0]                 wrData,
  input  logic                              rspValid,
  input  logic [WORD_W-1:0]                 rspWord,
  input  logic                              cmdReady,
  output logic                              cmdValid,
  output logic [WORD_W-1:0]                 cmdWord,
  output logic [WORD_W-1:0]                 rspHead,
  output logic                              rspEmpty,
  output logic [$clog2(RSP_DEPTH+1)-1:0]    rspLevel,
  output logic                              cmdFull,
  output logic                              rspAccept,
  output logic                              rspDrop
);
  localparam int CMD_LVL_W = $clog2(CMD_DEPTH+1);

  logic                 rspFull, cmdEmpty, cmdTake;
  logic [CMD_LVL_W-1:0] cmdLevel;

  assign cmdValid  = ~cmdEmpty;
  assign cmdTake   = cmdValid & cmdReady;
  assign rspAccept = rspValid & ~strobes.flush & (~rspFull | (strobes.rspPop & ~rspEmpty));
  assign rspDrop   = rspValid & ~strobes.flush & rspFull & ~strobes.rspPop;

  cdw_fifo #(.W(WORD_W), .DEPTH(RSP_DEPTH)) rspFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (rspValid),
    .pushData (rspWord),
    .pop      (strobes.rspPop),
    .headData (rspHead),
    .empty    (rspEmpty),
    .full     (rspFull),
    .level    (rspLevel)
  );

  cdw_fifo #(.W(WORD_W), .DEPTH(CMD_DEPTH)) cmdFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.cmdPush),
    .pushData (wrData),
    .pop      (cmdTake),
    .headData (cmdWord),
    .empty    (cmdEmpty),
    .full     (cmdFull),
    .level    (cmdLevel)
  );

  // R5: command buffer never claims more entries than it has
  a_r5_cmd_bound: assert property (@(posedge clk) disable iff (!rstN)
    cmdLevel <= CMD_LVL_W'(CMD_DEPTH));
  // R1: a word is never both accepted and dropped
  a_r1_accept_xor_drop: assert property (@(posedge clk) disable iff (!rstN)
    !(rspAccept && rspDrop));
endmodule

// File: rtl/cdw_ctrl.sv
`timescale 1ns/1ps
module cdw_ctrl
  import cdw_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int RSP_DEPTH = 40
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              dwClear,
  input  logic                              dwInit,
  input  logic                              cycStb,
  input  logic                              stationSel,
  input  logic [3:0]                        subAddr,
  input  logic [4:0]                        func,
  input  logic                              rspValid,
  input  logic                              rspLast,
  input  logic [WORD_W-1:0]                 rspHead,
  input  logic                              rspEmpty,
  input  logic [$clog2(RSP_DEPTH+1)-1:0]    rspLevel,
  input  logic                              cmdFull,
  input  logic                              rspAccept,
  input  logic                              rspDrop,
  output ctlStrobes_t                       strobes,
  output logic [WORD_W-1:0]                 rdData,
  output logic                              qResp,
  output logic                              xResp,
  output logic                              lamReq
);
  localparam int LVL_W = $clog2(RSP_DEPTH+1);

  logic clrIn, active;
  logic isRdFlags, isRdAdv, isFlush, isWrite, isTest, impl;
  logic l1, l2, ovf;
  logic l1Next;
  logic [WORD_W-1:0] rdNext;
  logic qNext;

  assign clrIn  = dwClear | dwInit;
  assign active = cycStb & stationSel & ~clrIn;

  assign isRdFlags = (func == FN_RD_FLAGS) && (subAddr <= 4'd1);
  assign isRdAdv   = (func == FN_RD_ADV)   && (subAddr <= 4'd1);
  assign isFlush   = (func == FN_FLUSH)    && (subAddr == 4'd0);
  assign isWrite   = (func == FN_WRITE);
  assign isTest    = (func == FN_TEST_L1)  && (subAddr == 4'd0);
  assign impl      = isRdFlags | isRdAdv | isFlush | isWrite | isTest;

  always_comb begin
    strobes.flush   = clrIn | (active & isFlush);
    strobes.rspPop  = active & isRdAdv & ~rspEmpty;
    strobes.cmdPush = active & isWrite & ~cmdFull;
  end

  always_comb begin
    rdNext = '0;
    qNext  = 1'b0;
    if (isRdFlags) begin
      rdNext = WORD_W'({ovf, l2, l1});
      qNext  = 1'b1;
    end else if (isRdAdv) begin
      rdNext = rspEmpty ? '0 : rspHead;
      qNext  = ~rspEmpty;
    end else if (isFlush) begin
      qNext  = 1'b1;
    end else if (isWrite) begin
      qNext  = ~cmdFull;
    end else if (isTest) begin
      qNext  = l1;
    end
  end

  assign l1Next = rspAccept | (rspLevel > LVL_W'(strobes.rspPop));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l1 <= 1'b0;
      l2 <= 1'b0;
      ovf <= 1'b0;
    end else if (strobes.flush) begin
      l1 <= 1'b0;
      l2 <= 1'b0;
      ovf <= 1'b0;
    end else begin
      l1 <= l1Next;
      if (rspValid && rspLast) l2 <= 1'b1;
      if (rspDrop) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      qResp  <= 1'b0;
      xResp  <= 1'b0;
    end else if (clrIn) begin
      rdData <= '0;
      qResp  <= 1'b0;
      xResp  <= 1'b0;
    end else if (active) begin
      rdData <= rdNext;
      qResp  <= qNext;
      xResp  <= impl;
    end
  end

  assign lamReq = l1 | l2;

  // R8: data flag mirrors the FIFO occupancy seen by the datapath
  a_r8_l1_follows: assert property (@(posedge clk) disable iff (!rstN)
    l1 == !rspEmpty);
  // R3: a read of an empty FIFO answers Q=0 with zero data
  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (active && isRdAdv && rspEmpty) |=> (!qResp && rdData == '0));
  // R4: flush function empties the FIFO and clears the flags
  a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    (active && isFlush) |=> (rspEmpty && !l2 && !ovf && qResp));
  // R5: a write into a full command buffer answers Q=0
  a_r5_reject_full: assert property (@(posedge clk) disable iff (!rstN)
    (active && isWrite && cmdFull) |=> !qResp);
  // R10: overflow stays set until a flush
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !strobes.flush) |=> ovf);
  // R11: unimplemented pairs answer X=0 and Q=0
  a_r11_unimpl: assert property (@(posedge clk) disable iff (!rstN)
    (active && !impl) |=> (!xResp && !qResp));
  // R12: no addressed strobe, no change of the held response
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !clrIn) |=> ($stable(qResp) && $stable(xResp) && $stable(rdData)));
  // R9: dataway clear forces an idle response
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrIn |=> (!qResp && !xResp && !lamReq));
endmodule

// File: rtl/cdw_buffered_if.sv
`timescale 1ns/1ps
module cdw_buffered_if
  import cdw_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int RSP_DEPTH = 40,
  parameter int CMD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dwClear,
  input  logic              dwInit,
  input  logic              cycStb,
  input  logic              stationSel,
  input  logic [3:0]        subAddr,
  input  logic [4:0]        func,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              qResp,
  output logic              xResp,
  output logic              lamReq,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [WORD_W-1:0] cmdWord,
  input  logic              rspValid,
  input  logic [WORD_W-1:0] rspWord,
  input  logic              rspLast
);
  localparam int RSP_LVL_W = $clog2(RSP_DEPTH+1);

  ctlStrobes_t          strobes;
  logic [WORD_W-1:0]    rspHead;
  logic                 rspEmpty, cmdFull, rspAccept, rspDrop;
  logic [RSP_LVL_W-1:0] rspLevel;

  cdw_ctrl #(.WORD_W(WORD_W), .RSP_DEPTH(RSP_DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .dwClear    (dwClear),
    .dwInit     (dwInit),
    .cycStb     (cycStb),
    .stationSel (stationSel),
    .subAddr    (subAddr),
    .func       (func),
    .rspValid   (rspValid),
    .rspLast    (rspLast),
    .rspHead    (rspHead),
    .rspEmpty   (rspEmpty),
    .rspLevel   (rspLevel),
    .cmdFull    (cmdFull),
    .rspAccept  (rspAccept),
    .rspDrop    (rspDrop),
    .strobes    (strobes),
    .rdData     (rdData),
    .qResp      (qResp),
    .xResp      (xResp),
    .lamReq     (lamReq)
  );

  cdw_datapath #(.WORD_W(WORD_W), .RSP_DEPTH(RSP_DEPTH), .CMD_DEPTH(CMD_DEPTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .rspValid  (rspValid),
    .rspWord   (rspWord),
    .cmdReady  (cmdReady),
    .cmdValid  (cmdValid),
    .cmdWord   (cmdWord),
    .rspHead   (rspHead),
    .rspEmpty  (rspEmpty),
    .rspLevel  (rspLevel),
    .cmdFull   (cmdFull),
    .rspAccept (rspAccept),
    .rspDrop   (rspDrop)
  );
endmodule

// File: tb/cdw_buffered_if_tb_top.sv
`timescale 1ns/1ps
module cdw_buffered_if_tb_top;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dwClear = 1'b0, dwInit = 1'b0, cycStb = 1'b0, stationSel = 1'b0;
  logic [3:0] subAddr = '0;
  logic [4:0] func = '0;
  logic [W-1:0] wrData = '0, rspWord = '0;
  logic cmdReady = 1'b0, rspValid = 1'b0, rspLast = 1'b0;
  logic [W-1:0] rdData, cmdWord;
  logic qResp, xResp, lamReq, cmdValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cdw_buffered_if dut_i (
    .clk(clk), .rstN(rstN), .dwClear(dwClear), .dwInit(dwInit),
    .cycStb(cycStb), .stationSel(stationSel), .subAddr(subAddr), .func(func),
    .wrData(wrData), .rdData(rdData), .qResp(qResp), .xResp(xResp),
    .lamReq(lamReq), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
    .rspValid(rspValid), .rspWord(rspWord), .rspLast(rspLast)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // dataway cycle; starts and ends at a falling edge, outputs valid on return
  task automatic dw(input logic n, input int f, input int a, input logic [W-1:0] wd,
                    input logic rv = 1'b0, input logic [W-1:0] rw = '0, input logic rl = 1'b0);
    cycStb = 1'b1; stationSel = n; func = 5'(f); subAddr = 4'(a); wrData = wd;
    rspValid = rv; rspWord = rw; rspLast = rl;
    @(posedge clk); @(negedge clk);
    cycStb = 1'b0; stationSel = 1'b0; rspValid = 1'b0; rspLast = 1'b0;
  endtask

  task automatic pushRsp(input logic [W-1:0] w, input logic last);
    rspValid = 1'b1; rspWord = w; rspLast = last;
    @(posedge clk); @(negedge clk);
    rspValid = 1'b0; rspLast = 1'b0;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset q", qResp, 0);
    chk("R9 reset x", xResp, 0);
    chk("R13 reset lam", lamReq, 0);
    chk("R5 reset cmdValid", cmdValid, 0);

    // R11 sweep of every function/subaddress on an idle block
    cmdReady = 1'b1;
    for (int f = 0; f < 32; f++) begin
      for (int a = 0; a < 16; a++) begin
        bit ex;
        bit eq;
        ex = ((f == 0 || f == 2) && a <= 1) || (f == 9 && a == 0) || f == 16 || (f == 27 && a == 0);
        eq = ((f == 0) && a <= 1) || (f == 9 && a == 0) || f == 16;
        dw(1'b1, f, a, W'(f * 16 + a));
        chk("R11 x decode", xResp, 32'(ex));
        chk("R11 q decode", qResp, 32'(eq));
        chk("R2 R3 idle read data", rdData, 0);
      end
    end
    repeat (2) @(negedge clk);
    cmdReady = 1'b0;
    chk("R5 buffer drained", cmdValid, 0);

    // R5 command buffer fill, reject, ordered drain
    for (int i = 0; i < 5; i++) begin
      dw(1'b1, 16, i, W'(24'h100 + i));
      chk("R5 write q", qResp, (i < 4) ? 1 : 0);
    end
    for (int i = 0; i < 4; i++) begin
      chk("R5 cmd valid", cmdValid, 1);
      chk("R5 cmd order", cmdWord, 32'h100 + i);
      cmdReady = 1'b1; @(negedge clk); cmdReady = 1'b0;
    end
    chk("R5 rejected word not stored", cmdValid, 0);

    // R1 R8 R7 R10 fill to depth, overflow, readback
    pushRsp(W'(3), 1'b0);
    dw(1'b1, 0, 1, '0);
    chk("R2 R8 flags after one word", rdData, 1);
    chk("R13 lam with L1", lamReq, 1);
    for (int i = 1; i < 40; i++) pushRsp(W'(i * 7 + 3), i == 39);
    pushRsp(W'(24'h999), 1'b0);
    dw(1'b1, 0, 0, '0);
    chk("R2 R10 flags full+ovf", rdData, 7);
    chk("R2 q", qResp, 1);
    dw(1'b1, 27, 0, '0);
    chk("R6 test L1 set", qResp, 1);
    for (int i = 0; i < 40; i++) begin
      dw(1'b1, 2, i % 2, '0);
      chk("R1 R3 read order", rdData, 32'(i * 7 + 3));
      chk("R3 read q", qResp, 1);
    end
    dw(1'b1, 2, 0, '0);
    chk("R1 R3 dropped/empty data", rdData, 0);
    chk("R3 empty q", qResp, 0);
    dw(1'b1, 27, 0, '0);
    chk("R6 R8 test L1 clear", qResp, 0);
    dw(1'b1, 0, 0, '0);
    chk("R10 R7 sticky after drain", rdData, 6);
    chk("R13 lam with L2", lamReq, 1);
    dw(1'b1, 9, 0, '0);
    chk("R4 flush q", qResp, 1);
    dw(1'b1, 0, 0, '0);
    chk("R4 flags cleared", rdData, 0);
    chk("R13 lam clear", lamReq, 0);

    // R7 block marker
    pushRsp(W'(11), 1'b0);
    pushRsp(W'(12), 1'b0);
    dw(1'b1, 0, 0, '0);
    chk("R7 L2 not set mid block", rdData, 1);
    pushRsp(W'(13), 1'b1);
    dw(1'b1, 0, 0, '0);
    chk("R7 L2 set at block end", rdData, 3);
    dw(1'b1, 9, 0, '0);

    // R8 simultaneous read and arrival
    pushRsp(W'(24'hA1), 1'b0);
    dw(1'b1, 2, 0, '0, 1'b1, W'(24'hB2), 1'b0);
    chk("R8 read during push", rdData, 32'hA1);
    dw(1'b1, 2, 1, '0);
    chk("R8 pushed word kept", rdData, 32'hB2);
    dw(1'b1, 27, 0, '0);
    chk("R8 empty after both", qResp, 0);

    // R4 flush with colliding arrival
    pushRsp(W'(24'hC3), 1'b0);
    dw(1'b1, 9, 0, '0, 1'b1, W'(24'hD4), 1'b1);
    dw(1'b1, 0, 0, '0);
    chk("R4 colliding word no L2", rdData, 0);
    dw(1'b1, 2, 0, '0);
    chk("R4 colliding word discarded", qResp, 0);

    // R12 unaddressed strobe
    pushRsp(W'(24'hE5), 1'b0);
    dw(1'b1, 27, 0, '0);
    dw(1'b0, 9, 0, '0);
    chk("R12 q held", qResp, 1);
    chk("R12 x held", xResp, 1);
    dw(1'b0, 2, 0, '0);
    chk("R12 data held", rdData, 0);

    // R11 unimplemented pairs change nothing
    dw(1'b1, 2, 2, '0);
    chk("R11 unimpl x", xResp, 0);
    chk("R11 unimpl q", qResp, 0);
    dw(1'b1, 9, 1, '0);
    dw(1'b1, 2, 1, '0);
    chk("R11 R12 fifo untouched", rdData, 32'hE5);

    // R14 response held across idle cycles
    repeat (3) @(negedge clk);
    chk("R14 held data", rdData, 32'hE5);

    // R9 dataway clear
    pushRsp(W'(24'hF6), 1'b1);
    dw(1'b1, 16, 0, W'(24'h777));
    dwClear = 1'b1; @(negedge clk); dwClear = 1'b0;
    chk("R9 clear q", qResp, 0);
    chk("R9 clear x", xResp, 0);
    chk("R9 clear data", rdData, 0);
    chk("R9 clear lam", lamReq, 0);
    chk("R9 clear cmd", cmdValid, 0);
    pushRsp(W'(24'h55), 1'b1);
    dwInit = 1'b1; @(negedge clk); dwInit = 1'b0;
    chk("R9 init lam", lamReq, 0);
    dw(1'b1, 2, 0, '0);
    chk("R9 init fifo empty", qResp, 0);

    done = 1'b1;
    finishRun();
  end
endmodule